// File: doc/BRIEF.md
# Special-Purpose CPU Register File

This block holds the sixteen 16-bit architectural registers of a small 16-bit processor. Entry 0 is the program counter, entry 1 the stack pointer, entry 2 the status word and entry 3 a source of zero. Entries 4 to 15 are plain storage. The surrounding core decodes instructions, runs the ALU and talks to memory. It uses this block through two combinational read ports, one synchronous write port with a byte/word select, a PC advance strobe, a relative-jump strobe with an offset, and push/pop strobes. The push/pop strobes move the stack pointer and present the stack address for the current access.

Each special entry applies its own rules inside the block, so the core never has to. The program counter and stack pointer always stay even. Entry 3 always reads as zero. A byte write zero-fills the upper half. The stack pointer moves down before a push and up after a pop. The status word keeps only its nine defined bits, and those bits drive dedicated flag and power-control outputs.

Top module: `cpu_regfile`

## Requirements
- R1: While reset is low, and at the first cycle after it is released, every register reads 0x0000, `pcOut` and `stackAddr` are 0x0000, and all flag outputs are 0.
- R2: A word write (`wrEn`=1, `wrByte`=0) to any of registers 4..15 stores `wrData`. Both read ports return each register independently.
- R3: Register 3 always reads 0x0000. A write to it has no effect.
- R4: A write to register 0 or register 1 stores the value with bit 0 forced to 0.
- R5: A byte write stores `wrData[7:0]` in bits 7..0 and clears bits 15..8. A byte read (`rdByteX`=1) returns bits 7..0 of the register with bits 15..8 at zero.
- R6: The PC update follows a priority order. An explicit write to register 0 wins. Next, `jumpEn` adds `jumpOff` with bit 0 cleared. Next, `pcInc` adds 2. Otherwise the PC holds its value.
- R7: If push is set without pop, SP decreases by 2 and `stackAddr` shows SP-2 in that cycle. If pop is set without push, `stackAddr` shows the current SP and SP then increases by 2. If push and pop are both set, SP is unchanged. An explicit write to register 1 wins over push and pop, and `stackAddr` then shows the current SP.
- R8: The status register has fixed bit positions: C=bit0, Z=bit1, N=bit2, interrupt enable=bit3, CPU-off=bit4, oscillator-off=bit5, clock-gate-0=bit6, clock-gate-1=bit7, V=bit8. Bits 15..9 always read as 0. Each stored bit drives its own output.
- R9: When a register is updated in a cycle, a read of that register in the same cycle returns the value it will hold after the edge (write-first). This covers PC advance, jumps and stack moves as well as port writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 4 | Read port A register index |
| rdByteA | input | 1 | Read port A byte width |
| rdDataA | output | 16 | Read port A data |
| rdAddrB | input | 4 | Read port B register index |
| rdByteB | input | 1 | Read port B byte width |
| rdDataB | output | 16 | Read port B data |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Write register index |
| wrByte | input | 1 | Write is byte width |
| wrData | input | 16 | Write data |
| pcInc | input | 1 | Advance PC by one word |
| jumpEn | input | 1 | Add jump offset to PC |
| jumpOff | input | 16 | Signed jump offset |
| push | input | 1 | Pre-decrement SP |
| pop | input | 1 | Post-increment SP |
| pcOut | output | 16 | Current PC |
| stackAddr | output | 16 | Address of the current stack access |
| flagC | output | 1 | Carry |
| flagZ | output | 1 | Zero |
| flagN | output | 1 | Negative |
| flagV | output | 1 | Signed overflow |
| intEn | output | 1 | Global interrupt enable |
| cpuOff | output | 1 | CPU-off control |
| oscOff | output | 1 | Oscillator-off control |
| clkGate0 | output | 1 | Clock-gate control 0 |
| clkGate1 | output | 1 | Clock-gate control 1 |

## Verification
The hardest situations to reach from the ports are the collisions. In these, an explicit write, a jump, a PC advance and push/pop all target PC or SP in one cycle, while a read port looks at that same register and must see the winner. Directed cycles first set up each pairing on purpose. After that, a long seeded random run sets every strobe independently, with read addresses steered toward registers 0..3 often enough that the collisions occur many times. A bench model that follows the priority rules predicts both the read data and the value after the edge.

// File: rtl/cpu_rf_pkg.sv
package cpu_rf_pkg;
  localparam int DATA_W = 16;
  localparam int NREG   = 16;
  localparam int ADDR_W = $clog2(NREG);
  localparam int BYTE_W = 8;

  localparam int REG_PC = 0;
  localparam int REG_SP = 1;
  localparam int REG_SR = 2;
  localparam int REG_CG = 3;

  // status word layout
  localparam int SR_C    = 0;
  localparam int SR_Z    = 1;
  localparam int SR_N    = 2;
  localparam int SR_GIE  = 3;
  localparam int SR_CPU  = 4;
  localparam int SR_OSC  = 5;
  localparam int SR_CG0  = 6;
  localparam int SR_CG1  = 7;
  localparam int SR_V    = 8;
  localparam int SR_BITS = 9;

  localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(2);
  localparam logic [DATA_W-1:0] EVEN_MASK = ~DATA_W'(1);

  typedef struct packed {
    logic [NREG-1:0] wrSel;
    logic            wrByte;
    logic            pcStep;
    logic            pcJump;
    logic            spDec;
    logic            spInc;
  } rfStrobe_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import cpu_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrByte,
  input  logic              pcInc,
  input  logic              jumpEn,
  input  logic              push,
  input  logic              pop,
  output rfStrobe_t         stb
);
  logic [NREG-1:0] sel;

  always_comb begin
    sel = '0;
    if (wrEn) sel[wrAddr] = 1'b1;
    sel[REG_CG] = 1'b0;  // constant entry has no storage
  end

  always_comb begin
    stb.wrSel  = sel;
    stb.wrByte = wrByte;
    stb.pcJump = jumpEn & ~sel[REG_PC];
    stb.pcStep = pcInc & ~jumpEn & ~sel[REG_PC];
    stb.spDec  = push & ~pop & ~sel[REG_SP];
    stb.spInc  = pop & ~push & ~sel[REG_SP];
  end

  // R6: at most one PC source is active
  a_r6_pc_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrSel[REG_PC], stb.pcJump, stb.pcStep}));
  // R7: at most one SP source is active
  a_r7_sp_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrSel[REG_SP], stb.spDec, stb.spInc}));
  // R3: the constant entry is never selected for writing
  a_r3_cg_never_written: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && wrAddr == ADDR_W'(REG_CG) |-> !stb.wrSel[REG_CG]);
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import cpu_rf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  rfStrobe_t          stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  jumpOff,
  input  logic [ADDR_W-1:0]  rdAddrA,
  input  logic               rdByteA,
  input  logic [ADDR_W-1:0]  rdAddrB,
  input  logic               rdByteB,
  output logic [DATA_W-1:0]  rdDataA,
  output logic [DATA_W-1:0]  rdDataB,
  output logic [DATA_W-1:0]  pcOut,
  output logic [DATA_W-1:0]  stackAddr,
  output logic [SR_BITS-1:0] srFlags
);
  localparam logic [DATA_W-1:0] SR_MASK = DATA_W'((1 << SR_BITS) - 1);

  logic [DATA_W-1:0] regQ [NREG];
  logic [DATA_W-1:0] regD [NREG];
  logic [DATA_W-1:0] wrVal;
  logic [DATA_W-1:0] rawA, rawB;

  assign wrVal = stb.wrByte ? {{(DATA_W-BYTE_W){1'b0}}, wrData[BYTE_W-1:0]} : wrData;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == REG_CG) begin : g_const
      assign regQ[i] = '0;
      assign regD[i] = '0;
    end else begin : g_store
      if (i == REG_PC) begin : g_pc
        always_comb begin
          if (stb.wrSel[i])    regD[i] = wrVal & EVEN_MASK;
          else if (stb.pcJump) regD[i] = regQ[i] + (jumpOff & EVEN_MASK);
          else if (stb.pcStep) regD[i] = regQ[i] + WORD_STEP;
          else                 regD[i] = regQ[i];
        end
      end else if (i == REG_SP) begin : g_sp
        always_comb begin
          if (stb.wrSel[i])   regD[i] = wrVal & EVEN_MASK;
          else if (stb.spDec) regD[i] = regQ[i] - WORD_STEP;
          else if (stb.spInc) regD[i] = regQ[i] + WORD_STEP;
          else                regD[i] = regQ[i];
        end
      end else if (i == REG_SR) begin : g_sr
        assign regD[i] = stb.wrSel[i] ? (wrVal & SR_MASK) : regQ[i];
      end else begin : g_gp
        assign regD[i] = stb.wrSel[i] ? wrVal : regQ[i];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) regQ[i] <= '0;
        else        regQ[i] <= regD[i];
      end
    end
  end

  // write-first read: the read sees the value being committed
  assign rawA    = regD[rdAddrA];
  assign rawB    = regD[rdAddrB];
  assign rdDataA = rdByteA ? {{(DATA_W-BYTE_W){1'b0}}, rawA[BYTE_W-1:0]} : rawA;
  assign rdDataB = rdByteB ? {{(DATA_W-BYTE_W){1'b0}}, rawB[BYTE_W-1:0]} : rawB;

  assign pcOut     = regQ[REG_PC];
  assign stackAddr = stb.spDec ? regQ[REG_SP] - WORD_STEP : regQ[REG_SP];
  assign srFlags   = regQ[REG_SR][SR_BITS-1:0];

  // R6: PC advance moves exactly one word
  a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pcStep |=> regQ[REG_PC] == $past(regQ[REG_PC]) + WORD_STEP);
  // R7: push lowers SP by one word
  a_r7_sp_push: assert property (@(posedge clk) disable iff (!rst_n)
    stb.spDec |=> regQ[REG_SP] == $past(regQ[REG_SP]) - WORD_STEP);
  // R7: pop raises SP by one word
  a_r7_sp_pop: assert property (@(posedge clk) disable iff (!rst_n)
    stb.spInc |=> regQ[REG_SP] == $past(regQ[REG_SP]) + WORD_STEP);
  // R4: PC and SP stay even
  a_r4_even_ptrs: assert property (@(posedge clk) disable iff (!rst_n)
    !regQ[REG_PC][0] && !regQ[REG_SP][0]);
  // R8: undefined status bits stay clear
  a_r8_sr_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    regQ[REG_SR][DATA_W-1:SR_BITS] == '0);
  // R3: reading entry 3 gives zero
  a_r3_cg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdAddrA == ADDR_W'(REG_CG) |-> rdDataA == '0);
  // R5: a byte read never shows an upper byte
  a_r5_byte_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdByteB |-> rdDataB[DATA_W-1:BYTE_W] == '0);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  rdAddrA,
  input  logic        rdByteA,
  output logic [15:0] rdDataA,
  input  logic [3:0]  rdAddrB,
  input  logic        rdByteB,
  output logic [15:0] rdDataB,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic        wrByte,
  input  logic [15:0] wrData,
  input  logic        pcInc,
  input  logic        jumpEn,
  input  logic [15:0] jumpOff,
  input  logic        push,
  input  logic        pop,
  output logic [15:0] pcOut,
  output logic [15:0] stackAddr,
  output logic        flagC,
  output logic        flagZ,
  output logic        flagN,
  output logic        flagV,
  output logic        intEn,
  output logic        cpuOff,
  output logic        oscOff,
  output logic        clkGate0,
  output logic        clkGate1
);
  rfStrobe_t          stb;
  logic [SR_BITS-1:0] srFlags;

  rf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrByte(wrByte),
    .pcInc(pcInc), .jumpEn(jumpEn), .push(push), .pop(pop), .stb(stb)
  );

  rf_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData), .jumpOff(jumpOff),
    .rdAddrA(rdAddrA), .rdByteA(rdByteA), .rdAddrB(rdAddrB), .rdByteB(rdByteB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .pcOut(pcOut), .stackAddr(stackAddr),
    .srFlags(srFlags)
  );

  assign flagC    = srFlags[SR_C];
  assign flagZ    = srFlags[SR_Z];
  assign flagN    = srFlags[SR_N];
  assign flagV    = srFlags[SR_V];
  assign intEn    = srFlags[SR_GIE];
  assign cpuOff   = srFlags[SR_CPU];
  assign oscOff   = srFlags[SR_OSC];
  assign clkGate0 = srFlags[SR_CG0];
  assign clkGate1 = srFlags[SR_CG1];
endmodule

// File: tb/cpu_regfile_bench.sv
module cpu_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic        rdByteA = 1'b0, rdByteB = 1'b0, wrEn = 1'b0, wrByte = 1'b0;
  logic [15:0] wrData = '0, jumpOff = '0;
  logic        pcInc = 1'b0, jumpEn = 1'b0, push = 1'b0, pop = 1'b0;
  logic [15:0] rdDataA, rdDataB, pcOut, stackAddr;
  logic        flagC, flagZ, flagN, flagV, intEn, cpuOff, oscOff, clkGate0, clkGate1;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;
  logic [15:0] m [16];
  logic [15:0] nx [16];

  always #10 clk = ~clk;  // 50 MHz

  cpu_regfile u_cpu_regfile (
    .clk(clk), .rst_n(rst_n),
    .rdAddrA(rdAddrA), .rdByteA(rdByteA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdByteB(rdByteB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrByte(wrByte), .wrData(wrData),
    .pcInc(pcInc), .jumpEn(jumpEn), .jumpOff(jumpOff), .push(push), .pop(pop),
    .pcOut(pcOut), .stackAddr(stackAddr),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV), .intEn(intEn),
    .cpuOff(cpuOff), .oscOff(oscOff), .clkGate0(clkGate0), .clkGate1(clkGate1)
  );

  function automatic logic [15:0] fmtWr();
    return wrByte ? {8'h00, wrData[7:0]} : wrData;
  endfunction

  function automatic logic [15:0] nextVal(int r);
    logic hit;
    hit = wrEn && (wrAddr == 4'(r));
    if (r == 3) return 16'h0000;
    if (r == 0) begin
      if (hit)    return fmtWr() & 16'hFFFE;
      if (jumpEn) return m[0] + (jumpOff & 16'hFFFE);
      if (pcInc)  return m[0] + 16'd2;
      return m[0];
    end
    if (r == 1) begin
      if (hit)          return fmtWr() & 16'hFFFE;
      if (push && !pop) return m[1] - 16'd2;
      if (pop && !push) return m[1] + 16'd2;
      return m[1];
    end
    if (r == 2) return hit ? (fmtWr() & 16'h01FF) : m[2];
    return hit ? fmtWr() : m[r];
  endfunction

  function automatic logic [15:0] rdExp(logic [3:0] a, logic b);
    logic [15:0] v;
    v = nextVal(int'(a));
    return b ? {8'h00, v[7:0]} : v;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // inputs are already set (after a falling edge); check, then commit
  task automatic cycle(string tag);
    logic [15:0] sa;
    #2;
    chk({tag, " rdA"}, rdDataA, rdExp(rdAddrA, rdByteA));
    chk({tag, " rdB"}, rdDataB, rdExp(rdAddrB, rdByteB));
    chk({tag, " pcOut"}, pcOut, m[0]);
    sa = (push && !pop && !(wrEn && wrAddr == 4'd1)) ? m[1] - 16'd2 : m[1];
    chk({tag, " stackAddr R7"}, stackAddr, sa);
    chk({tag, " flags R8"},
        {7'd0, flagV, clkGate1, clkGate0, oscOff, cpuOff, intEn, flagN, flagZ, flagC},
        m[2] & 16'h01FF);
    for (int r = 0; r < 16; r++) nx[r] = nextVal(r);
    @(posedge clk);
    for (int r = 0; r < 16; r++) m[r] = nx[r];
    @(negedge clk);
  endtask

  task automatic idle();
    wrEn = 0; wrByte = 0; pcInc = 0; jumpEn = 0; push = 0; pop = 0;
    rdByteA = 0; rdByteB = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d, logic b);
    wrEn = 1; wrAddr = a; wrData = d; wrByte = b;
  endtask

  initial begin
    for (int r = 0; r < 16; r++) m[r] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state observed while reset is held
    for (int r = 0; r < 16; r++) begin
      rdAddrA = 4'(r); rdAddrB = 4'(15 - r); #2;
      chk("R1 reset rdA", rdDataA, 16'h0000);
      chk("R1 reset rdB", rdDataB, 16'h0000);
      @(negedge clk);
    end
    chk("R1 reset pcOut", pcOut, 16'h0000);
    chk("R1 reset stackAddr", stackAddr, 16'h0000);
    rst_n = 1;
    rdAddrA = 4'd7; rdAddrB = 4'd2;
    cycle("R1 after release");

    // R2: word writes, two independent reads
    idle(); wr(4'd5, 16'hA5C3, 0); rdAddrA = 4'd5; rdAddrB = 4'd4; cycle("R2/R9 write r5");
    idle(); wr(4'd4, 16'h1357, 0); rdAddrA = 4'd5; rdAddrB = 4'd4; cycle("R2 write r4");
    idle(); rdAddrA = 4'd4; rdAddrB = 4'd5; cycle("R2 readback");
    // R5: byte write and byte read
    idle(); wr(4'd6, 16'hFFEE, 1); rdAddrA = 4'd6; cycle("R5 byte write");
    idle(); rdAddrA = 4'd5; rdByteA = 1; rdAddrB = 4'd6; cycle("R5 byte read");
    // R3: entry 3 ignores writes
    idle(); wr(4'd3, 16'h1234, 0); rdAddrA = 4'd3; rdAddrB = 4'd3; cycle("R3 write");
    idle(); rdAddrA = 4'd3; rdAddrB = 4'd3; cycle("R3 after write");
    // R4: PC/SP keep even
    idle(); wr(4'd0, 16'h1235, 0); rdAddrA = 4'd0; cycle("R4 pc odd write");
    idle(); wr(4'd1, 16'h0281, 0); rdAddrA = 4'd1; cycle("R4 sp odd write");
    idle(); wr(4'd1, 16'hFF7F, 1); rdAddrA = 4'd1; cycle("R4/R5 sp byte write");
    idle(); wr(4'd1, 16'h0280, 0); cycle("R4 sp restore");
    // R7: stack moves
    idle(); push = 1; rdAddrA = 4'd1; cycle("R7/R9 push");
    idle(); push = 1; cycle("R7 push 2");
    idle(); pop = 1; rdAddrA = 4'd1; cycle("R7 pop");
    idle(); push = 1; pop = 1; rdAddrA = 4'd1; cycle("R7 push+pop");
    idle(); push = 1; wr(4'd1, 16'h0400, 0); rdAddrA = 4'd1; cycle("R7 write beats push");
    idle(); rdAddrA = 4'd1; cycle("R7 check");
    // R6: PC sources and priority
    idle(); pcInc = 1; rdAddrA = 4'd0; cycle("R6/R9 pc inc");
    idle(); jumpEn = 1; jumpOff = 16'h0011; rdAddrA = 4'd0; cycle("R6 jump odd offset");
    idle(); jumpEn = 1; jumpOff = 16'hFFF0; pcInc = 1; rdAddrA = 4'd0; cycle("R6 jump beats inc");
    idle(); pcInc = 1; jumpEn = 1; wr(4'd0, 16'h8000, 0); rdAddrA = 4'd0; cycle("R6 write beats all");
    idle(); rdAddrA = 4'd0; cycle("R6 check");
    // R8: status word
    idle(); wr(4'd2, 16'hFFFF, 0); rdAddrA = 4'd2; cycle("R8 sr all ones");
    idle(); rdAddrA = 4'd2; cycle("R8 flags");
    idle(); wr(4'd2, 16'h0155, 0); rdAddrA = 4'd2; cycle("R8 sr pattern");
    idle(); wr(4'd2, 16'h00AA, 0); rdAddrA = 4'd2; cycle("R8 sr pattern 2");
    idle(); cycle("R8 flags 2");

    // random mix
    void'($urandom(32'd7129));
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] rv;
      rv = $urandom();
      wrEn = rv[0]; wrByte = rv[1] & rv[2]; pcInc = rv[3]; jumpEn = rv[4] & rv[5];
      push = rv[6] & rv[7]; pop = rv[8] & rv[9];
      rdByteA = rv[10] & rv[11]; rdByteB = rv[12] & rv[13];
      wrAddr = rv[14] ? {2'b00, rv[16:15]} : rv[20:17];
      rdAddrA = rv[21] ? {2'b00, rv[23:22]} : rv[27:24];
      rdAddrB = rv[28] ? wrAddr : 4'($urandom_range(0, 15));
      wrData = 16'($urandom()); jumpOff = 16'($urandom());
      cycle("R2/R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule